// File: doc/BRIEF.md
# Selectable-Source Clock Divider with Glitch-Free Stop

This block produces one divided clock from one of up to eight source clocks. A single 32-bit control word holds three things: the divide ratio minus one, a stop flag, and a source-select field. The control word is written and read back through a simple synchronous register port. A parameter sets the number of sources to 1, 4 or 8. That choice decides which bits of the control word form the select field.

In this model every source is an enable pulse on one system clock. Each pulse of the selected source counts as one source cycle. The output is a registered level that only changes on a selected source pulse.

Changes to the ratio, the stop flag and the source selection are all held back until the end of the current output period. At that point the output is low, so no shortened pulse can appear. A stopped divider must never be left with a zero divide field, so the register repairs such a write on its own.

Top module: `selclk_divider`

## Requirements
- R1: After reset, `reg_rdata` reads 0x0000013F (stopped, divide field 63, source 0), `div_out` is 0 and `clk_enabled` is 0.
- R2: Control bits [5:0] hold the ratio N minus one, so N runs from 1 to 64. When running with N ≥ 2, the output repeats every N selected source pulses.
- R3: For N ≥ 2, the output is high for the first floor(N/2) source cycles of each period and low for the rest. It only changes in the system clock after a selected pulse.
- R4: For N = 1, the output passes the selected source through: it is high for one system clock after each selected pulse and low otherwise.
- R5: Control bit 8 set means stop. The output then stays low. `clk_enabled` reads as the inverse of bit 8 in the clock after the write.
- R6: Stopping and restarting take effect only at a period boundary, where the output is low. A high phase already in progress runs to its end. A stopped divider starts on the next selected pulse, and that pulse opens a high phase.
- R7: A new ratio written while running takes effect only at the next period boundary.
- R8: With 8 sources the select field is bits [14:12]. With 4 sources it is bits [7:6]. With 1 source there is no select field. While running, a new selection applies from the next period boundary. While stopped, it applies at once.
- R9: A write that sets bit 8 with a zero divide field stores 63 in the divide field instead.
- R10: Bits outside the divide field, the stop bit and the select field read as zero, and writes to them are ignored.
- R11: Pulses on sources other than the active one do not change the output or the period position.
- R12: When a write and a boundary pulse arrive in the same clock, the boundary uses the control value from before the write. The new value waits for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| src_tick | input | NUM_SRC | One enable pulse per source cycle, one bit per source |
| div_out | output | 1 | Divided clock level |
| clk_enabled | output | 1 | High when the stop bit is clear |

## Verification
The risky overlap is a register write that lands in the same system clock as the selected pulse that closes a period. In that clock the divider must decide between the old and the new ratio, stop flag and select value.

The bench drives the write strobe and the closing pulse on the same edge. It writes stop together with a new ratio. It expects one more full period at the old ratio, then a low output once the following boundary has applied the stop.

A second overlap is a select change that races the boundary pulse of the old source. The bench judges it by which source's pulses advance the output afterwards.

// File: rtl/selclk_pkg.sv
package selclk_pkg;

    localparam int DIV_W    = 6;
    localparam int STOP_POS = 8;
    localparam int SEL_MAXW = 3;
    localparam logic [31:0] CTRL_RESET = 32'h0000_013F;

    typedef struct packed {
        logic                stop;
        logic [SEL_MAXW-1:0] sel;
        logic [DIV_W-1:0]    div_m1;
    } div_cfg_t;

    function automatic int sel_width(input int n_src);
        if (n_src == 8)      return 3;
        else if (n_src == 4) return 2;
        else                 return 0;
    endfunction

    function automatic int sel_lsb(input int n_src);
        if (n_src == 8)      return 12;
        else if (n_src == 4) return 6;
        else                 return 0;
    endfunction

    function automatic logic [31:0] write_mask(input int n_src);
        logic [31:0] m;
        m = (32'd1 << STOP_POS) | ((32'd1 << DIV_W) - 32'd1);
        if (sel_width(n_src) > 0)
            m = m | (((32'd1 << sel_width(n_src)) - 32'd1) << sel_lsb(n_src));
        return m;
    endfunction

    // A stopped word never keeps a zero divide field.
    function automatic logic [31:0] repair_word(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        if (r[STOP_POS] && (r[DIV_W-1:0] == '0))
            r[DIV_W-1:0] = '1;
        return r;
    endfunction

endpackage

// File: rtl/selclk_regs.sv
module selclk_regs
    import selclk_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output div_cfg_t    cfg
);
    localparam logic [31:0] MASK = write_mask(NUM_SRC);
    localparam int SW = sel_width(NUM_SRC);
    localparam int SL = sel_lsb(NUM_SRC);
    localparam logic [SEL_MAXW-1:0] SEL_MASK = SEL_MAXW'((1 << SW) - 1);

    logic [31:0] ctrl_q;
    logic [31:0] sel_shift;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (we)
            ctrl_q <= repair_word(wdata & MASK);
    end

    always_comb begin
        sel_shift  = ctrl_q >> SL;
        cfg.div_m1 = ctrl_q[DIV_W-1:0];
        cfg.stop   = ctrl_q[STOP_POS];
        cfg.sel    = sel_shift[SEL_MAXW-1:0] & SEL_MASK;
    end

    assign rdata = ctrl_q;

    p_stop_div_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[STOP_POS] |-> (ctrl_q[DIV_W-1:0] != '0));
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~MASK) == 32'd0);
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctrl_q));

endmodule

// File: rtl/selclk_srcsel.sv
module selclk_srcsel
    import selclk_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0]  src_tick,
    input  logic [SEL_MAXW-1:0] act_sel,
    output logic                tick
);
    localparam int SW  = sel_width(NUM_SRC);
    localparam int SWX = (SW > 0) ? SW : 1;

    generate
        if (SW == 0) begin : g_single
            assign tick = src_tick[0];
        end else begin : g_mux
            logic [SWX-1:0] idx;
            assign idx  = act_sel[SWX-1:0];
            assign tick = src_tick[idx];
        end
    endgenerate

endmodule

// File: rtl/selclk_core.sv
module selclk_core
    import selclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  div_cfg_t            cfg,
    output logic [SEL_MAXW-1:0] act_sel,
    output logic                div_out
);
    logic [DIV_W-1:0]    cnt_q, cnt_n;
    logic [DIV_W-1:0]    act_q, act_n;
    logic [SEL_MAXW-1:0] sel_q, sel_n;
    logic                run_q, run_n;
    logic                out_q, out_n;
    logic                boundary;
    logic [DIV_W:0]      half;

    // A period closes on the last count, or on any pulse while stopped.
    assign boundary = tick && (!run_q || (cnt_q == act_q));

    always_comb begin
        run_n = run_q;
        act_n = act_q;
        cnt_n = cnt_q;
        if (tick) begin
            if (boundary) begin
                run_n = !cfg.stop;
                act_n = cfg.div_m1;
                cnt_n = '0;
            end else begin
                cnt_n = cnt_q + 1'b1;
            end
        end
        half = ({1'b0, act_n} + 1'b1) >> 1;
        if (!run_n)
            out_n = 1'b0;
        else if (act_n == '0)
            out_n = tick;
        else
            out_n = ({1'b0, cnt_n} < half);
        sel_n = (!run_q || boundary) ? cfg.sel : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '1;
            sel_q <= '0;
            run_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            act_q <= act_n;
            sel_q <= sel_n;
            run_q <= run_n;
            out_q <= out_n;
        end
    end

    assign act_sel = sel_q;
    assign div_out = out_q;

    p_rise_after_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(out_q) |-> $past(tick));
    p_ratio_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(boundary));
    p_run_at_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(run_q) |-> $past(boundary));
    p_stop_in_low_phase_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(run_q) && ($past(act_q) != '0)) |-> !$past(out_q));
    p_stopped_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !tick) |=> !out_q);

endmodule

// File: rtl/selclk_divider.sv
module selclk_divider
    import selclk_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               div_out,
    output logic               clk_enabled
);
    div_cfg_t            cfg;
    logic [SEL_MAXW-1:0] act_sel;
    logic                sel_tick;

    selclk_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    selclk_srcsel #(.NUM_SRC(NUM_SRC)) u_srcsel (
        .src_tick (src_tick),
        .act_sel  (act_sel),
        .tick     (sel_tick)
    );

    selclk_core u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (sel_tick),
        .cfg     (cfg),
        .act_sel (act_sel),
        .div_out (div_out)
    );

    assign clk_enabled = !cfg.stop;

endmodule

// File: tb/selclk_divider_tb.sv
module selclk_divider_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        we, we4;
    logic [31:0] wdata, wdata4;
    logic [31:0] rdata, rdata4;
    logic [7:0]  tick8;
    logic [3:0]  tick4;
    logic        div_out, div4, clk_en, en4;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    selclk_divider #(.NUM_SRC(8)) u_dut (
        .clk(clk), .rst(rst), .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata),
        .src_tick(tick8), .div_out(div_out), .clk_enabled(clk_en)
    );

    selclk_divider #(.NUM_SRC(4)) u_dut4 (
        .clk(clk), .rst(rst), .reg_we(we4), .reg_wdata(wdata4), .reg_rdata(rdata4),
        .src_tick(tick4), .div_out(div4), .clk_enabled(en4)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; we = 1'b0; we4 = 1'b0; wdata = '0; wdata4 = '0; tick8 = '0; tick4 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wr4(input logic [31:0] v);
        @(negedge clk); we4 = 1'b1; wdata4 = v;
        @(negedge clk); we4 = 1'b0;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); tick8[s] = 1'b1;
        @(negedge clk); tick8 = '0;
    endtask

    task automatic pulse4(input int s);
        @(negedge clk); tick4[s] = 1'b1;
        @(negedge clk); tick4 = '0;
    endtask

    task automatic wr_pulse(input logic [31:0] v, input int s);
        @(negedge clk); we = 1'b1; wdata = v; tick8[s] = 1'b1;
        @(negedge clk); we = 1'b0; tick8 = '0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", rdata, 32'h0000_013F);
        chk("R1 div_out", {31'd0, div_out}, 32'd0);
        chk("R1 clk_enabled", {31'd0, clk_en}, 32'd0);
        chk("R1 rdata4", rdata4, 32'h0000_013F);
    endtask

    task automatic t_div4();
        int highs = 0;
        do_reset();
        wr(32'h0000_0003);
        chk("R5 enabled after run write", {31'd0, clk_en}, 32'd1);
        for (int i = 0; i < 8; i++) begin
            pulse(0);
            chk("R2/R3 ratio 4 pattern", {31'd0, div_out}, ((i % 4) < 2) ? 32'd1 : 32'd0);
            highs += div_out;
        end
        chk("R3 ratio 4 high count", highs, 32'd4);
    endtask

    task automatic t_odd_and_max();
        int highs = 0;
        int first_low = -1;
        do_reset();
        wr(32'h0000_0004);
        for (int i = 0; i < 10; i++) begin
            pulse(0);
            chk("R3 ratio 5 pattern", {31'd0, div_out}, ((i % 5) < 2) ? 32'd1 : 32'd0);
        end
        do_reset();
        wr(32'h0000_003F);
        for (int i = 0; i < 64; i++) begin
            pulse(0);
            highs += div_out;
            if (!div_out && first_low < 0) first_low = i;
        end
        chk("R3 ratio 64 high count", highs, 32'd32);
        chk("R3 ratio 64 first low", first_low, 32'd32);
        pulse(0);
        chk("R2 ratio 64 new period", {31'd0, div_out}, 32'd1);
    endtask

    task automatic t_bypass();
        do_reset();
        wr(32'h0000_0000);
        for (int i = 0; i < 3; i++) begin
            pulse(0);
            chk("R4 pass-through high", {31'd0, div_out}, 32'd1);
            @(negedge clk);
            chk("R4 pass-through low", {31'd0, div_out}, 32'd0);
        end
    endtask

    task automatic t_ratio_change();
        logic exp_seq [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        do_reset();
        wr(32'h0000_0003);
        pulse(0); pulse(0);
        wr(32'h0000_0001);
        for (int i = 0; i < 6; i++) begin
            pulse(0);
            chk("R7 ratio change at boundary", {31'd0, div_out}, {31'd0, exp_seq[i]});
        end
    endtask

    task automatic t_stop_restart();
        logic exp_seq [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
        do_reset();
        wr(32'h0000_0003);
        pulse(0);
        wr(32'h0000_0103);
        chk("R5 enabled reads inverse of stop", {31'd0, clk_en}, 32'd0);
        chk("R5 stop readback", rdata, 32'h0000_0103);
        chk("R6 high phase kept", {31'd0, div_out}, 32'd1);
        for (int i = 0; i < 6; i++) begin
            pulse(0);
            chk("R6 stop at boundary", {31'd0, div_out}, {31'd0, exp_seq[i]});
        end
        wr(32'h0000_0003);
        chk("R6 no output before pulse", {31'd0, div_out}, 32'd0);
        pulse(0);
        chk("R6 restart opens high phase", {31'd0, div_out}, 32'd1);
    endtask

    task automatic t_repair_and_mask();
        do_reset();
        wr(32'h0000_0100);
        chk("R9 stop with zero divide", rdata, 32'h0000_013F);
        wr(32'h0000_0105);
        chk("R9 nonzero divide kept", rdata, 32'h0000_0105);
        wr(32'h0000_0000);
        chk("R9 zero divide when running", rdata, 32'h0000_0000);
        wr(32'hFFFF_FFFF);
        chk("R10 all ones masked", rdata, 32'h0000_713F);
        wr(32'hFFFF_8EC0);
        chk("R10 unused bits ignored", rdata, 32'h0000_0000);
    endtask

    task automatic t_select();
        do_reset();
        wr(32'h0000_2001);
        pulse(0);
        chk("R11 other source while stopped", {31'd0, div_out}, 32'd0);
        pulse(2);
        chk("R8 select bits 14:12 = 2", {31'd0, div_out}, 32'd1);
        pulse(0);
        chk("R11 other source while running", {31'd0, div_out}, 32'd1);
        pulse(2);
        chk("R8 source 2 second pulse", {31'd0, div_out}, 32'd0);
        wr(32'h0000_5001);
        pulse(5);
        chk("R8 new select waits for boundary", {31'd0, div_out}, 32'd0);
        pulse(2);
        chk("R8 boundary on old source", {31'd0, div_out}, 32'd1);
        pulse(2);
        chk("R11 old source ignored after switch", {31'd0, div_out}, 32'd1);
        pulse(5);
        chk("R8 source 5 now active", {31'd0, div_out}, 32'd0);
    endtask

    task automatic t_four_sources();
        do_reset();
        wr4(32'hFFFF_FFFF);
        chk("R8/R10 four-source mask", rdata4, 32'h0000_01FF);
        wr4(32'h0000_0081);
        pulse4(2);
        chk("R8 select bits 7:6 = 2", {31'd0, div4}, 32'd1);
        pulse4(1);
        chk("R11 four-source other pulse", {31'd0, div4}, 32'd1);
        pulse4(2);
        chk("R8 four-source second pulse", {31'd0, div4}, 32'd0);
    endtask

    task automatic t_collision();
        do_reset();
        wr(32'h0000_0001);
        pulse(0);
        pulse(0);
        wr_pulse(32'h0000_0103, 0);
        chk("R12 boundary uses old word", {31'd0, div_out}, 32'd1);
        chk("R12 status follows write", {31'd0, clk_en}, 32'd0);
        pulse(0);
        chk("R12 old ratio kept", {31'd0, div_out}, 32'd0);
        pulse(0);
        chk("R12 stop at next boundary", {31'd0, div_out}, 32'd0);
        pulse(0);
        chk("R12 stays stopped", {31'd0, div_out}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_div4();
        t_odd_and_max();
        t_bypass();
        t_ratio_change();
        t_stop_restart();
        t_repair_and_mask();
        t_select();
        t_four_sources();
        t_collision();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule